// File: doc/BRIEF.md
# Split-Read Seconds Counter

This block keeps wall-clock time as a 48-bit count of seconds. A single-cycle `tick_i` enable arrives at 32768 Hz. A power-of-two prescaler turns those ticks into one count increment per second. Software reaches the count over a 32-bit register port. The lower 32 bits of the count form one word and the upper 16 bits form another.

A 32-bit bus cannot read 48 bits in one access, so a carry into the upper bits between two reads could return a torn value. To avoid this, a mode field in the control word can select split-read freezing. In that mode, reading the low word captures the current high word into a shadow register. The next high-word read returns the shadow and releases it. Software must therefore read the low word first.

Time is loaded in two steps. A low-word write is staged, and the following high-word write commits both halves together and restarts the prescaler. A 48-bit compare value, held in its own register pair, produces a one-cycle `alarm_o` pulse when the count becomes equal to it.

Top module: `sec_counter_top`

## Requirements
- R1: After reset the count is 0, the mode field is 0, the compare value is all ones (low word 0xFFFFFFFF, high word 0x0000FFFF) and `alarm_o` is low.
- R2: The count advances by one after every 2^PRESC_W cycles with `tick_i` high. Cycles with `tick_i` low change neither the count nor the prescaler.
- R3: A read at byte address 0x08 returns count bits 31:0. A read at 0x0C returns count bits 47:32 in data bits 15:0, with bits 31:16 zero.
- R4: With mode field value 2, a low-word read captures the high word. The next high-word read returns the captured value even if a carry has changed the live high word, and that read releases the capture.
- R5: With mode field values 0, 1 or 3, a high-word read returns the live high word.
- R6: A write to 0x08 only stages the low half and leaves the count unchanged. The next write to 0x0C loads the count from both halves and clears the prescaler, so the next increment comes a full 2^PRESC_W ticks later.
- R7: Bits 31:16 of a write to 0x0C are ignored.
- R8: The compare value is written and read back at 0x20 (bits 31:0) and 0x24 (bits 47:32 in 15:0). Bits 31:16 of a write to 0x24 are ignored and read as zero.
- R9: `alarm_o` is high for exactly one cycle each time the count becomes equal to the compare value, and it stays low while the two remain equal.
- R10: The control word at 0x50 holds the mode field in bits 25:24. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; read side effects occur at the clock edge |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` while `rd_en_i` is high, otherwise zero |
| alarm_o | output | 1 | One-cycle pulse when the count reaches the compare value |

## Verification
The split-read test first loads a count of 0x1_FFFF_FFFF, then reads the low word, then lets one second elapse before reading the high word. A design that failed to capture, or captured on the wrong access, would return 2 instead of 1. The same sequence is repeated with freezing off, where 2 is the correct answer; a design that froze unconditionally would fail there.

The load test checks three things. A lone low-word write must not disturb the count. A partial prescaler count must not carry over a load, or the increment would arrive early. Junk in the upper bits of the high-word write must not leak into the count.

The alarm test counts the seconds through and past the compare value and expects exactly one pulse. A level-style output, or a compare that kept re-triggering, would give a different pulse count.

// File: rtl/sec_cnt_pkg.sv
package sec_cnt_pkg;
  localparam logic [7:0] ADDR_CNT_LO = 8'h08;
  localparam logic [7:0] ADDR_CNT_HI = 8'h0C;
  localparam logic [7:0] ADDR_ALM_LO = 8'h20;
  localparam logic [7:0] ADDR_ALM_HI = 8'h24;
  localparam logic [7:0] ADDR_CTL    = 8'h50;
  localparam int         FMODE_LSB   = 24;

  typedef enum logic [1:0] {
    FM_LIVE0 = 2'd0,
    FM_LIVE1 = 2'd1,
    FM_SPLIT = 2'd2,
    FM_LIVE3 = 2'd3
  } fmode_e;
endpackage

// File: rtl/sec_cnt_prescaler.sv
module sec_cnt_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic carry_o
);
  logic [PRESC_W-1:0] div_q;

  assign carry_o = tick_i && !clear_i && (&div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clear_i) div_q <= '0;
    else if (tick_i)  div_q <= div_q + 1'b1;
  end

  assert_presc_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (div_q == '0));
  assert_presc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(div_q));
endmodule

// File: rtl/sec_cnt_core.sv
module sec_cnt_core #(
  parameter int CNT_W = 48,
  parameter int LO_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             carry_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [LO_W-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] cnt_q;
  logic [LO_W-1:0]  stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      if (wr_lo_i) stage_q <= wdata_i;
      if (wr_hi_i)      cnt_q <= {wdata_i[HI_W-1:0], stage_q};  // commit both halves at once
      else if (carry_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_i && !wr_hi_i) |=> $stable(cnt_q));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cnt_q[CNT_W-1:LO_W] == $past(wdata_i[HI_W-1:0])) &&
                (cnt_q[LO_W-1:0] == $past(stage_q)));
endmodule

// File: rtl/sec_cnt_snapshot.sv
module sec_cnt_snapshot #(
  parameter int HI_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_lo_i,
  input  logic            rd_hi_i,
  input  logic            freeze_i,
  input  logic [HI_W-1:0] live_hi_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] shadow_q;
  logic            frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      frozen_q <= 1'b0;
    end else if (rd_lo_i && freeze_i) begin
      shadow_q <= live_hi_i;
      frozen_q <= 1'b1;
    end else if (rd_hi_i) begin
      frozen_q <= 1'b0;
    end
  end

  assign hi_o = (freeze_i && frozen_q) ? shadow_q : live_hi_i;

  assert_shadow_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !rd_lo_i) |=> $stable(shadow_q));
  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |=> !frozen_q);
endmodule

// File: rtl/sec_cnt_alarm.sv
module sec_cnt_alarm #(
  parameter int CNT_W = 48,
  parameter int LO_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [LO_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] alm_o,
  output logic             fire_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] alm_q;
  logic             match, match_q, fire_q;

  assign match = (cnt_i == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q   <= '1;
      match_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      if (wr_lo_i) alm_q[LO_W-1:0]     <= wdata_i;
      if (wr_hi_i) alm_q[CNT_W-1:LO_W] <= wdata_i[HI_W-1:0];
      match_q <= match;
      fire_q  <= match && !match_q;  // rising edge of equality only
    end
  end

  assign alm_o  = alm_q;
  assign fire_o = fire_q;

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  assert_fire_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_o) |-> $past(match));
endmodule

// File: rtl/sec_counter_top.sv
module sec_counter_top
  import sec_cnt_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int LO_W    = 32,
  parameter int PRESC_W = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [7:0]      addr_i,
  input  logic [LO_W-1:0] wdata_i,
  output logic [LO_W-1:0] rdata_o,
  output logic            alarm_o
);
  localparam int HI_W = CNT_W - LO_W;

  fmode_e           fmode_q;
  logic [CNT_W-1:0] cnt, alm;
  logic [HI_W-1:0]  hi_view;
  logic             carry, wr_cnt_lo, wr_cnt_hi, wr_alm_lo, wr_alm_hi;
  logic             rd_cnt_lo, rd_cnt_hi;
  logic [LO_W-1:0]  rd_mux;

  assign wr_cnt_lo = wr_en_i && (addr_i == ADDR_CNT_LO);
  assign wr_cnt_hi = wr_en_i && (addr_i == ADDR_CNT_HI);
  assign wr_alm_lo = wr_en_i && (addr_i == ADDR_ALM_LO);
  assign wr_alm_hi = wr_en_i && (addr_i == ADDR_ALM_HI);
  assign rd_cnt_lo = rd_en_i && (addr_i == ADDR_CNT_LO);
  assign rd_cnt_hi = rd_en_i && (addr_i == ADDR_CNT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmode_q <= FM_LIVE0;
    else if (wr_en_i && addr_i == ADDR_CTL)
      fmode_q <= fmode_e'(wdata_i[FMODE_LSB+1:FMODE_LSB]);
  end

  sec_cnt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i, .rst_ni, .tick_i, .clear_i(wr_cnt_hi), .carry_o(carry)
  );

  sec_cnt_core #(.CNT_W(CNT_W), .LO_W(LO_W)) u_core (
    .clk_i, .rst_ni, .carry_i(carry), .wr_lo_i(wr_cnt_lo), .wr_hi_i(wr_cnt_hi),
    .wdata_i, .cnt_o(cnt)
  );

  sec_cnt_snapshot #(.HI_W(HI_W)) u_snap (
    .clk_i, .rst_ni, .rd_lo_i(rd_cnt_lo), .rd_hi_i(rd_cnt_hi),
    .freeze_i(fmode_q == FM_SPLIT), .live_hi_i(cnt[CNT_W-1:LO_W]), .hi_o(hi_view)
  );

  sec_cnt_alarm #(.CNT_W(CNT_W), .LO_W(LO_W)) u_alarm (
    .clk_i, .rst_ni, .wr_lo_i(wr_alm_lo), .wr_hi_i(wr_alm_hi), .wdata_i,
    .cnt_i(cnt), .alm_o(alm), .fire_o(alarm_o)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_CNT_LO: rd_mux = cnt[LO_W-1:0];
      ADDR_CNT_HI: rd_mux = {{(LO_W-HI_W){1'b0}}, hi_view};
      ADDR_ALM_LO: rd_mux = alm[LO_W-1:0];
      ADDR_ALM_HI: rd_mux = {{(LO_W-HI_W){1'b0}}, alm[CNT_W-1:LO_W]};
      ADDR_CTL:    rd_mux[FMODE_LSB+1:FMODE_LSB] = fmode_q;
      default:     rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_en_i ? rd_mux : '0;

  assert_ctl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_CTL) |=> $stable(fmode_q));
endmodule

// File: tb/sec_counter_top_tb_top.sv
`timescale 1ns/1ps
module sec_counter_top_tb_top;
  localparam int PW = 4;
  localparam int SEC = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alarm;
  int          n_chk = 0, n_err = 0, pulses = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sec_counter_top #(.CNT_W(48), .LO_W(32), .PRESC_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_o(alarm)
  );

  always @(negedge clk) if (alarm) pulses++;

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic load(logic [31:0] lo, logic [31:0] hi);
    bus_wr(8'h08, lo);
    bus_wr(8'h0C, hi);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h08, d); check("R1 cnt lo", d, 0);
    bus_rd(8'h0C, d); check("R1 cnt hi", d, 0);
    bus_rd(8'h50, d); check("R1 ctl", d, 0);
    bus_rd(8'h20, d); check("R1 alm lo", d, 32'hFFFF_FFFF);
    bus_rd(8'h24, d); check("R1 alm hi", d, 32'h0000_FFFF);
    check("R1 alarm_o", alarm, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    ticks(SEC);     bus_rd(8'h08, d); check("R2 one second", d, 1);
    repeat (20) @(posedge clk);
    bus_rd(8'h08, d); check("R2 idle no change", d, 1);
    ticks(SEC - 1); bus_rd(8'h08, d); check("R2 partial", d, 1);
    ticks(1);       bus_rd(8'h08, d); check("R2 second carry", d, 2);
  endtask

  task automatic t_ctl;
    logic [31:0] d;
    bus_wr(8'h50, 32'hFFFF_FFFF); bus_rd(8'h50, d); check("R10 ctl mask", d, 32'h0300_0000);
    bus_wr(8'h50, 32'h0200_0000); bus_rd(8'h50, d); check("R10 ctl split", d, 32'h0200_0000);
  endtask

  task automatic t_split;
    logic [31:0] d;
    load(32'hFFFF_FFFF, 32'h1);
    bus_rd(8'h08, d); check("R3 lo word", d, 32'hFFFF_FFFF);
    ticks(SEC);
    bus_rd(8'h0C, d); check("R4 frozen hi", d, 1);
    bus_rd(8'h08, d); check("R3 lo after carry", d, 0);
    bus_rd(8'h0C, d); check("R4 fresh capture", d, 2);
  endtask

  task automatic t_live;
    logic [31:0] d;
    bus_wr(8'h50, 32'h0000_0000);
    load(32'hFFFF_FFFF, 32'h1);
    bus_rd(8'h08, d); ticks(SEC);
    bus_rd(8'h0C, d); check("R5 live hi mode0", d, 2);
    bus_wr(8'h50, 32'h0300_0000);
    load(32'hFFFF_FFFF, 32'h4);
    bus_rd(8'h08, d); ticks(SEC);
    bus_rd(8'h0C, d); check("R5 live hi mode3", d, 5);
  endtask

  task automatic t_load;
    logic [31:0] d;
    load(32'h5, 32'hABCD_0003);
    bus_rd(8'h0C, d); check("R7 hi upper ignored", d, 3);
    bus_rd(8'h08, d); check("R7 lo", d, 5);
    bus_wr(8'h08, 32'h1234);
    bus_rd(8'h08, d); check("R6 staged only", d, 5);
    ticks(SEC / 2);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h08, d); check("R6 loaded lo", d, 32'h1234);
    bus_rd(8'h0C, d); check("R6 loaded hi", d, 0);
    ticks(SEC - 1); bus_rd(8'h08, d); check("R6 prescaler cleared", d, 32'h1234);
    ticks(1);       bus_rd(8'h08, d); check("R6 first increment", d, 32'h1235);
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    bus_wr(8'h20, 32'd12);
    bus_wr(8'h24, 32'hFFFF_0000);
    bus_rd(8'h20, d); check("R8 alm lo", d, 12);
    bus_rd(8'h24, d); check("R8 alm hi masked", d, 0);
    load(32'd10, 32'd0);
    repeat (3) @(posedge clk);
    pulses = 0;
    ticks(SEC * 2 - 1);
    repeat (3) @(posedge clk);
    check("R9 not yet", pulses, 0);
    ticks(1);
    repeat (3) @(posedge clk);
    check("R9 fires once", pulses, 1);
    ticks(SEC * 2);
    repeat (3) @(posedge clk);
    check("R9 no repeat", pulses, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_count();
    t_ctl();
    t_split();
    t_live();
    t_load();
    t_alarm();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule